// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the software-facing half of a simple byte-oriented UART. A byte-wide register port, decoded on the low six address bits, exposes two mode registers behind a shared offset, a status register, a packed command register, a receive/transmit data port and an interrupt status/mask pair. Bit-level serialization, baud generation and line error checks live elsewhere. The controller only tracks enable state, queues received bytes and hands one transmit byte at a time to a downstream serializer.

The two mode registers share one offset. A pointer picks which one a read or write reaches, and the pointer advances to the second register after any write. A single command write carries three fields: a miscellaneous action, a transmitter enable action and a receiver enable action. They take effect in that order within the same write, so a reset action followed by an enable in the same byte leaves the side enabled. Received bytes enter a small queue from a valid/ready receive interface, and a break indication queues a zero byte. One level interrupt is raised whenever an unmasked interrupt status bit is set.

Top module: `uart_regctl`

## Requirements
- R1: After reset, status reads 0x08 (transmit empty only). Both mode registers, the mode pointer, interrupt status, interrupt mask and both enables are zero. `irq`, `tx_valid` and `rx_ready` are low.
- R2: Only `bus_addr[5:0]` is decoded, so addresses 0x40 apart alias. Writes at 0x04 are ignored. Reads at 0x08, 0x10, 0x18, 0x1C and every unmapped offset return 0x00.
- R3: Offset 0x00 reads and writes the mode register chosen by the pointer. Any write there moves the pointer to the second register. Only a command with bits [6:4] = 1 returns the pointer to the first.
- R4: A command byte at 0x08 holds a miscellaneous code in bits [6:4], a transmitter code in [3:2] and a receiver code in [1:0]. In the two enable fields, 1 enables and 2 disables. The miscellaneous action is applied before the enable fields, so 0x34 leaves the transmitter enabled.
- R5: Status bits are: 0x01 receive data present, 0x02 receive queue full, 0x04 transmitter enabled, 0x08 transmit buffer empty.
- R6: A write at 0x0C loads the transmit byte and clears transmit-empty. `tx_valid` is high while the transmitter is enabled and a byte is pending, and `tx_data` holds steady until `tx_ready`. Transmit-empty is set in the cycle after acceptance. Miscellaneous code 3 disables the transmitter and discards the pending byte.
- R7: The receive queue holds RX_DEPTH bytes in arrival order. `rx_ready` is high only while the receiver is enabled and the queue is not full. A read strobe at 0x0C returns the oldest byte and removes it. An empty queue reads 0x00.
- R8: Miscellaneous code 2 disables the receiver and empties the queue, clearing status bits 0x01 and 0x02. A receiver-enable field in the same byte (0x21) re-enables the receiver.
- R9: An `rx_break` pulse sets interrupt status bit 0x04 and queues a 0x00 byte, even with the receiver disabled. If the queue is full, the zero replaces the newest entry. Miscellaneous code 5 clears bit 0x04.
- R10: Interrupt status (read at 0x14) bit 0x01 equals transmitter enabled. Bit 0x02 follows queue-full when bit 6 of the first mode register is set, and follows data-present otherwise.
- R11: A write at 0x14 sets the interrupt mask. `irq` is high exactly when interrupt status AND mask is nonzero.
- R12: Miscellaneous codes 0, 4, 6 and 7 and the enable-field code 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (pops receive data at 0x0C) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive queue accepts a byte |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break detected pulse |

## Verification
Every piece of internal state reaches a port within one clock. A wrong enable shows at once in status and in `tx_valid` or `rx_ready`, and a misplaced mode pointer shows on the next read of offset 0x00. Queue ordering or overwrite faults show as a wrong byte on the next pop. A wrong interrupt-select or break flag shows on `irq` and at 0x14 in the cycle after the event that set it. Field-ordering faults in the command byte show up as a wrong enable bit read right after the single write that combines a reset with an enable.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

  localparam int OFF_W     = 6;
  localparam int NUM_MODE  = 2;
  localparam int RXSEL_BIT = 6;

  localparam logic [OFF_W-1:0] OFF_MODE = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT = 6'h04;
  localparam logic [OFF_W-1:0] OFF_CMD  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_DATA = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_INT  = 6'h14;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_ON   = 2'd1,
    EN_OFF  = 2'd2,
    EN_RSVD = 2'd3
  } en_cmd_e;

  typedef struct packed {
    misc_e   misc;
    en_cmd_e txf;
    en_cmd_e rxf;
  } cmd_t;

  // reset action first, then the enable field of the same command byte
  function automatic logic next_enable(logic cur, logic reset_hit, en_cmd_e f);
    logic v;
    v = reset_hit ? 1'b0 : cur;
    case (f)
      EN_ON:   v = 1'b1;
      EN_OFF:  v = 1'b0;
      default: v = v;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] pack_status(logic rx_any, logic rx_full,
                                             logic tx_on, logic tx_emp);
    return {4'b0000, tx_emp, tx_on, rx_full, rx_any};
  endfunction

  function automatic logic [7:0] pack_isr(logic tx_on, logic rx_any, logic rx_full,
                                          logic sel_full, logic brk);
    return {5'b00000, brk, (sel_full ? rx_full : rx_any), tx_on};
  endfunction

endpackage

// File: rtl/urc_mode_bank.sv
module urc_mode_bank
  import uart_regctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       clr_ptr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic [7:0] mode_first,
  output logic       ptr
);
  logic [7:0] mode_q [NUM_MODE];

  for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n)                        mode_q[g] <= '0;
      else if (wr_en && (ptr == 1'(g)))  mode_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= 1'b0;
    else if (clr_ptr)  ptr <= 1'b0;
    else if (wr_en)    ptr <= 1'b1;
  end

  assign rd_data    = mode_q[ptr];
  assign mode_first = mode_q[0];

  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr);
  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ptr |=> !ptr);
endmodule

// File: rtl/urc_rx_queue.sv
module urc_rx_queue #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       pop,
  output logic [7:0] head,
  output logic       full,
  output logic       empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [7:0]    mem_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n, cnt_pop;
  logic          pop_ok;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == FULL_CNT);
  assign pop_ok = pop && !empty;
  assign head   = empty ? 8'h00 : mem_q[0];

  always_comb begin
    cnt_pop = cnt_q - CW'(pop_ok);
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_ok && (i < DEPTH - 1)) mem_n[i] = mem_q[i + 1];
      else                           mem_n[i] = mem_q[i];
    end
    cnt_n = cnt_pop;
    if (push) begin
      // a push into a full queue overwrites the newest entry
      for (int i = 0; i < DEPTH; i++) begin
        if ((cnt_pop == FULL_CNT) ? (i == DEPTH - 1) : (CW'(i) == cnt_pop))
          mem_n[i] = push_data;
      end
      if (cnt_pop != FULL_CNT) cnt_n = cnt_pop + 1'b1;
    end
    if (flush) cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !flush |=> full);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/urc_tx_hold.sv
module urc_tx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       discard,
  input  logic       enable,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       buf_empty
);
  logic pend_q;
  logic accept;

  assign tx_valid  = pend_q && enable;
  assign accept    = tx_valid && tx_ready;
  assign buf_empty = !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      tx_data <= '0;
    end else if (discard) begin
      pend_q  <= 1'b0;
    end else if (load) begin
      pend_q  <= 1'b1;
      tx_data <= load_data;
    end else if (accept) begin
      pend_q  <= 1'b0;
    end
  end

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !load && !discard && enable |=> tx_valid && $stable(tx_data));
  assert_tx_accept_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !load |=> buf_empty);
  assert_load_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load && !discard |=> !buf_empty);
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
  import uart_regctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_break
);
  logic [OFF_W-1:0] off;
  logic unused_bits;
  assign off         = bus_addr[OFF_W-1:0];
  assign unused_bits = ^{bus_addr[ADDR_W-1:OFF_W], bus_wdata[7]};

  // decoded events, named for the assertions
  logic wr_mode, wr_cmd, wr_txd, wr_mask, rd_pop;
  assign wr_mode = bus_wr && (off == OFF_MODE);
  assign wr_cmd  = bus_wr && (off == OFF_CMD);
  assign wr_txd  = bus_wr && (off == OFF_DATA);
  assign wr_mask = bus_wr && (off == OFF_INT);
  assign rd_pop  = bus_rd && (off == OFF_DATA);

  cmd_t cmd;
  assign cmd = cmd_t'(bus_wdata[6:0]);

  logic ptr_clr, rx_flush, tx_discard, brk_clr;
  assign ptr_clr    = wr_cmd && (cmd.misc == MISC_PTR_RST);
  assign rx_flush   = wr_cmd && (cmd.misc == MISC_RX_RST);
  assign tx_discard = wr_cmd && (cmd.misc == MISC_TX_RST);
  assign brk_clr    = wr_cmd && (cmd.misc == MISC_BRK_CLR);

  logic       tx_en_q, rx_en_q, brk_q;
  logic [7:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      brk_q   <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (wr_cmd) begin
        tx_en_q <= next_enable(tx_en_q, tx_discard, cmd.txf);
        rx_en_q <= next_enable(rx_en_q, rx_flush, cmd.rxf);
      end
      if (rx_break)     brk_q <= 1'b1;
      else if (brk_clr) brk_q <= 1'b0;
      if (wr_mask) mask_q <= bus_wdata;
    end
  end

  logic [7:0] mode_rd, mode_first;
  logic       mode_ptr;

  urc_mode_bank u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_mode),
    .clr_ptr    (ptr_clr),
    .wdata      (bus_wdata),
    .rd_data    (mode_rd),
    .mode_first (mode_first),
    .ptr        (mode_ptr)
  );

  logic       rxq_full, rxq_empty, rxq_push;
  logic [7:0] rxq_head, rxq_in;

  assign rx_ready = rx_en_q && !rxq_full;
  assign rxq_push = rx_break || (rx_valid && rx_ready);
  assign rxq_in   = rx_break ? 8'h00 : rx_data;

  urc_rx_queue #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (rxq_push),
    .push_data (rxq_in),
    .pop       (rd_pop),
    .head      (rxq_head),
    .full      (rxq_full),
    .empty     (rxq_empty)
  );

  logic tx_emp;

  urc_tx_hold u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_txd),
    .load_data (bus_wdata),
    .discard   (tx_discard),
    .enable    (tx_en_q),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .buf_empty (tx_emp)
  );

  logic [7:0] status_w, isr_w;
  assign status_w = pack_status(!rxq_empty, rxq_full, tx_en_q, tx_emp);
  assign isr_w    = pack_isr(tx_en_q, !rxq_empty, rxq_full, mode_first[RXSEL_BIT], brk_q);
  assign irq      = |(isr_w & mask_q);

  always_comb begin
    case (off)
      OFF_MODE: bus_rdata = mode_rd;
      OFF_STAT: bus_rdata = status_w;
      OFF_DATA: bus_rdata = rxq_head;
      OFF_INT:  bus_rdata = isr_w;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assert_tx_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && (cmd.txf == EN_ON) |=> status_w[2]);
  assert_rx_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && (cmd.rxf == EN_OFF) |=> !rx_ready);
  assert_break_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> isr_w[2] && !rxq_empty);
  assert_break_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_clr && !rx_break |=> !isr_w[2]);
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 8'h00));
  assert_flush_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (status_w[1:0] == 2'b00));
endmodule

// File: tb/uart_regctl_tb.sv
`timescale 1ns/1ps
module uart_regctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, tx_valid, rx_ready;
  logic       tx_ready = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] tx_data;
  logic [7:0] rx_data = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_regctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_break(rx_break)
  );

  // {op, req, addr, value}: op 1 = write value, op 2 = read and expect value
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    24'h210408, 24'h210000, 24'h211400,                       // R1 reset state
    24'h1300A5, 24'h230000, 24'h13003C, 24'h23003C,           // R3 pointer
    24'h130077, 24'h230077, 24'h130810, 24'h2300A5,           // R3 reset pointer
    24'h2280A5, 24'h1204FF, 24'h220408,                       // R2 alias, 0x04 write ignored
    24'h221000, 24'h221800, 24'h221C00, 24'h220800,           // R2 zero offsets
    24'h222000, 24'h223C00,
    24'h140804, 24'h25040C, 24'h2A1401,                       // R4 R5 R10 tx enable
    24'h140834, 24'h24040C,                                   // R4 misc before tx field
    24'h140808, 24'h250408, 24'h2A1400,                       // R5 R10 disable
    24'h1C084F, 24'h2C0408, 24'h1C0860                        // R12 reserved codes
  };

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    bus_addr = 8'h0C; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(logic [7:0] d);
    @(negedge clk);
    rx_data = d; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk_pulse();
    @(negedge clk);
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:20] == 4'h1) bus_write(VEC[i][15:8], VEC[i][7:0]);
      else begin
        peek(VEC[i][15:8], v);
        chk($sformatf("R%0d vec%0d", VEC[i][19:16], i), v, VEC[i][7:0]);
      end
    end
    peek(8'h00, v); chk("R12 mode after misc6", v, 8'hA5);

    // R11 interrupt mask
    bus_write(8'h14, 8'h01);
    bus_write(8'h08, 8'h04);
    #1 chk("R11 irq on", {7'd0, irq}, 8'h01);
    bus_write(8'h14, 8'h02);
    #1 chk("R11 irq masked", {7'd0, irq}, 8'h00);
    bus_write(8'h14, 8'h00);

    // R6 transmit hand-off
    bus_write(8'h0C, 8'h5A);
    #1 chk("R6 valid", {7'd0, tx_valid}, 8'h01);
    chk("R6 data", tx_data, 8'h5A);
    peek(8'h04, v); chk("R6 status pending", v, 8'h04);
    repeat (3) @(negedge clk);
    #1 chk("R6 held", {tx_valid, tx_data[6:0]}, {1'b1, 7'h5A});
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    #1 chk("R6 valid after accept", {7'd0, tx_valid}, 8'h00);
    peek(8'h04, v); chk("R6 status after accept", v, 8'h0C);

    bus_write(8'h08, 8'h08);
    bus_write(8'h0C, 8'h33);
    #1 chk("R6 disabled no valid", {7'd0, tx_valid}, 8'h00);
    peek(8'h04, v); chk("R6 status disabled pending", v, 8'h00);
    bus_write(8'h08, 8'h04);
    #1 chk("R6 valid on enable", {tx_valid, tx_data[6:0]}, {1'b1, 7'h33});
    bus_write(8'h08, 8'h30);
    #1 chk("R6 discard", {7'd0, tx_valid}, 8'h00);
    peek(8'h04, v); chk("R6 status after tx reset", v, 8'h08);

    // R7 receive queue
    bus_write(8'h08, 8'h01);
    #1 chk("R4 rx enable", {7'd0, rx_ready}, 8'h01);
    rx_push(8'h11);
    peek(8'h04, v); chk("R5 rx present", v, 8'h09);
    rx_push(8'h22); rx_push(8'h33); rx_push(8'h44);
    peek(8'h04, v); chk("R7 full status", v, 8'h0B);
    #1 chk("R7 rx_ready full", {7'd0, rx_ready}, 8'h00);
    peek(8'h14, v); chk("R10 isr ready select", v, 8'h02);
    rx_push(8'h55);
    bus_write(8'h00, 8'h40);
    peek(8'h14, v); chk("R10 isr full select", v, 8'h02);
    pop(v); chk("R7 pop 1", v, 8'h11);
    peek(8'h14, v); chk("R10 isr not full", v, 8'h00);
    pop(v); chk("R7 pop 2", v, 8'h22);
    pop(v); chk("R7 pop 3", v, 8'h33);
    pop(v); chk("R7 pop 4", v, 8'h44);
    pop(v); chk("R7 empty pop", v, 8'h00);
    peek(8'h04, v); chk("R7 empty status", v, 8'h08);

    // R9 break
    brk_pulse();
    peek(8'h14, v); chk("R9 break flag", v, 8'h04);
    pop(v); chk("R9 zero byte", v, 8'h00);
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3); rx_push(8'hA4);
    brk_pulse();
    peek(8'h14, v); chk("R9 isr full+break", v, 8'h06);
    pop(v); chk("R9 keep 1", v, 8'hA1);
    pop(v); chk("R9 keep 2", v, 8'hA2);
    pop(v); chk("R9 keep 3", v, 8'hA3);
    pop(v); chk("R9 overwrite newest", v, 8'h00);
    bus_write(8'h08, 8'h50);
    peek(8'h14, v); chk("R9 break clear", v, 8'h00);

    // R8 receiver reset
    rx_push(8'h66); rx_push(8'h77);
    bus_write(8'h08, 8'h20);
    peek(8'h04, v); chk("R8 status flushed", v, 8'h08);
    #1 chk("R8 rx disabled", {7'd0, rx_ready}, 8'h00);
    peek(8'h0C, v); chk("R8 data gone", v, 8'h00);
    bus_write(8'h08, 8'h21);
    #1 chk("R8 reset then enable", {7'd0, rx_ready}, 8'h01);

    // R12 reserved codes keep state
    bus_write(8'h08, 8'h03);
    #1 chk("R12 rx code 3", {7'd0, rx_ready}, 8'h01);
    bus_write(8'h08, 8'h70);
    #1 chk("R12 misc 7", {7'd0, rx_ready}, 8'h01);
    peek(8'h04, v); chk("R12 status", v, 8'h08);
    bus_write(8'h08, 8'h02);
    #1 chk("R4 rx disable", {7'd0, rx_ready}, 8'h00);

    // R1 reset mid-run
    bus_write(8'h14, 8'h01);
    bus_write(8'h08, 8'h04);
    bus_write(8'h0C, 8'h99);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    chk("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
    peek(8'h04, v); chk("R1 status after reset", v, 8'h08);
    peek(8'h14, v); chk("R1 isr after reset", v, 8'h00);
    peek(8'h00, v); chk("R1 mode after reset", v, 8'h00);
    bus_write(8'h00, 8'h12);
    bus_write(8'h08, 8'h10);
    peek(8'h00, v); chk("R1 pointer reset to first", v, 8'h12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule